// File: doc/BRIEF.md
# Readback Stream Fault Injector

This block sits in a byte-serial configuration readback path, ahead of a CRC error checker. It corrupts selected bytes on purpose, so that the checker's response to a real upset can be tested while the device keeps running. Test software reaches the block through a test access port. A 10-bit instruction register selects a 21-bit staging register. That register holds an error kind, a byte offset and an XOR mask.

The staging register is never used directly. A working copy drives the corruption logic, and the copy is refreshed only at frame boundaries outside a guard window. The window runs from the start of the last frame of a pass to the end of the first frame of the next pass. Only bytes of the first frame of a pass can be corrupted. Every other byte passes through with no added latency. A status flag reports when the working copy holds a kind that injects.

Top module: `rb_fault_injector`

## Requirements
- R1: The instruction register shifts LSB first from `tdi` and updates on `tap_update_ir`. A capture loads 10'b0000000001. When it holds 10'b0000010101, the data path of the port is the 21-bit staging register. Capture copies the staging register into a shift path, shifting is LSB first with bit 0 on `tdo`, and update copies the shift path into the staging register. With any other instruction, `tdo` is 0 during a data shift and the staging register does not change.
- R2: While `user_mode` is low, data capture, data shift and data update of the staging register are ignored.
- R3: Command bits [20:19] select the kind. 2'b01 corrupts a single byte, 2'b10 corrupts two adjacent bytes and 2'b00 corrupts nothing.
- R4: Kind 2'b11 behaves exactly like 2'b00.
- R5: Bits [18:8] give the byte index within the frame, counted from 0 after `rb_frame_start`. Bits [7:0] are XORed into the target byte. The result appears on `rb_byte_out` in the same cycle as `rb_byte_vld`.
- R6: Bytes of any frame not flagged first with `rb_frame_first` pass through unchanged.
- R7: At `rb_frame_end`, the working register takes the staging register's value, except at the end of a frame flagged last and not first. A frame that is both first and last does load.
- R8: In double mode, the byte at the offset and the byte at offset+1 are both XORed with the mask.
- R9: A byte whose index is FRAME_BYTES or larger is never corrupted, and nothing carries over into the next frame.
- R10: `err_test_mode` is high exactly when the working register holds kind 01 or 10. It changes in the cycle after a frame end that loads.
- R11: Synchronous reset clears the staging and working registers to zero, drops `err_test_mode` and selects an instruction other than the injection one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| user_mode | input | 1 | Device is in user mode |
| tdi | input | 1 | Test data in |
| tap_capture_ir | input | 1 | Capture-IR state strobe |
| tap_shift_ir | input | 1 | Shift-IR state strobe |
| tap_update_ir | input | 1 | Update-IR state strobe |
| tap_capture_dr | input | 1 | Capture-DR state strobe |
| tap_shift_dr | input | 1 | Shift-DR state strobe |
| tap_update_dr | input | 1 | Update-DR state strobe |
| tdo | output | 1 | Test data out |
| rb_frame_start | input | 1 | Pulse opening a readback frame |
| rb_frame_first | input | 1 | With the start pulse: frame is the first of the pass |
| rb_frame_last | input | 1 | With the start pulse: frame is the last of the pass |
| rb_frame_end | input | 1 | Pulse closing the open frame |
| rb_byte_vld | input | 1 | Readback byte strobe |
| rb_byte_in | input | 8 | Readback byte from the configuration memory |
| rb_byte_out | output | 8 | Readback byte, possibly corrupted |
| err_test_mode | output | 1 | Working register holds an injecting kind |

## Verification
The assertions assume a well-formed frame protocol. A start pulse arrives only while no frame is open. An end pulse arrives only while one is open, and byte strobes come only inside an open frame. The assertions also assume that the port's state strobes are mutually exclusive single-cycle pulses. The bench keeps within these assumptions by driving every frame as start pulse, byte run, end pulse. Access-port sequences are never overlapped with frame strobes in the same cycle, and only one state strobe is raised per cycle.

// File: rtl/rfi_pkg.sv
package rfi_pkg;
  localparam int KIND_W = 2;
  localparam int OFS_W  = 11;
  localparam int MASK_W = 8;
  localparam int CMD_W  = KIND_W + OFS_W + MASK_W;

  typedef enum logic [KIND_W-1:0] {
    K_NONE   = 2'b00,
    K_SINGLE = 2'b01,
    K_DOUBLE = 2'b10,
    K_BAD    = 2'b11
  } kind_e;

  typedef struct packed {
    kind_e             kind;
    logic [OFS_W-1:0]  ofs;
    logic [MASK_W-1:0] mask;
  } cmd_t;

  function automatic logic kind_active(kind_e k);
    return (k == K_SINGLE) || (k == K_DOUBLE);
  endfunction
endpackage

// File: rtl/rfi_tap_regs.sv
module rfi_tap_regs
  import rfi_pkg::*;
#(
  parameter int               IR_W   = 10,
  parameter logic [IR_W-1:0]  OPCODE = 10'b0000010101
) (
  input  logic clk,
  input  logic rst,
  input  logic user_mode,
  input  logic tdi,
  input  logic cap_ir,
  input  logic shift_ir,
  input  logic upd_ir,
  input  logic cap_dr,
  input  logic shift_dr,
  input  logic upd_dr,
  output logic tdo,
  output cmd_t stage
);
  localparam logic [IR_W-1:0] IR_CAPTURE = IR_W'(1);

  logic [IR_W-1:0]  ir_sh;
  logic [IR_W-1:0]  ir_q;
  logic [CMD_W-1:0] dr_sh;
  cmd_t             stage_q;
  logic             sel;
  logic             dr_en;

  assign sel   = (ir_q == OPCODE);
  assign dr_en = sel && user_mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      ir_sh <= '0;
      ir_q  <= '1;
    end else begin
      if (cap_ir)        ir_sh <= IR_CAPTURE;
      else if (shift_ir) ir_sh <= {tdi, ir_sh[IR_W-1:1]};
      if (upd_ir)        ir_q  <= ir_sh;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dr_sh   <= '0;
      stage_q <= '0;
    end else if (dr_en) begin
      if (cap_dr)        dr_sh <= stage_q;
      else if (shift_dr) dr_sh <= {tdi, dr_sh[CMD_W-1:1]};
      if (upd_dr)        stage_q <= cmd_t'(dr_sh);
    end
  end

  always_comb begin
    if (shift_ir)             tdo = ir_sh[0];
    else if (sel && shift_dr) tdo = dr_sh[0];
    else                      tdo = 1'b0;
  end

  assign stage = stage_q;

  AST_STAGE_FROZEN_OFF_USER: assert property (@(posedge clk) disable iff (rst)
    !user_mode |=> $stable(stage_q)); // R2
  AST_SHIFT_FROZEN_OFF_USER: assert property (@(posedge clk) disable iff (rst)
    !user_mode |=> $stable(dr_sh)); // R2
  AST_STAGE_ONLY_ON_UPDATE: assert property (@(posedge clk) disable iff (rst)
    !upd_dr |=> $stable(stage_q)); // R1
  AST_IR_ONLY_ON_UPDATE: assert property (@(posedge clk) disable iff (rst)
    !upd_ir |=> $stable(ir_q)); // R1
endmodule

// File: rtl/rfi_frame_track.sv
module rfi_frame_track #(
  parameter int FRAME_BYTES = 64,
  parameter int IDX_W       = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frm_start,
  input  logic             frm_first,
  input  logic             frm_last,
  input  logic             frm_end,
  input  logic             byte_vld,
  output logic             in_first,
  output logic [IDX_W-1:0] byte_idx,
  output logic             idx_ok,
  output logic             load
);
  localparam logic [IDX_W-1:0] IDX_MAX = '1;
  localparam logic [IDX_W-1:0] IDX_LIM = IDX_W'(FRAME_BYTES);

  logic             in_frame;
  logic             cur_first;
  logic             in_window;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_frame  <= 1'b0;
      cur_first <= 1'b0;
      in_window <= 1'b0;
      idx_q     <= '0;
    end else begin
      if (frm_start) begin
        in_frame  <= 1'b1;
        cur_first <= frm_first;
        idx_q     <= '0;
        if (frm_first || frm_last) in_window <= 1'b1;
      end else if (frm_end) begin
        in_frame  <= 1'b0;
        cur_first <= 1'b0;
        if (cur_first) in_window <= 1'b0;
      end else if (byte_vld && idx_q != IDX_MAX) begin
        idx_q <= idx_q + IDX_W'(1);
      end
    end
  end

  assign in_first = in_frame && cur_first;
  assign byte_idx = idx_q;
  assign idx_ok   = idx_q < IDX_LIM;
  assign load     = frm_end && in_frame && (cur_first || !in_window);

  AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    frm_start |-> !in_frame); // R7
  AST_END_WHEN_OPEN: assert property (@(posedge clk) disable iff (rst)
    frm_end |-> in_frame); // R7
  AST_BYTE_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    byte_vld |-> in_frame && !frm_start && !frm_end); // R5
  AST_WINDOW_OPENS: assert property (@(posedge clk) disable iff (rst)
    (frm_start && frm_last) |=> in_window); // R7
  AST_INDEX_RESTARTS: assert property (@(posedge clk) disable iff (rst)
    frm_start |=> idx_q == '0); // R9
endmodule

// File: rtl/rfi_corrupt.sv
module rfi_corrupt
  import rfi_pkg::*;
#(
  parameter int IDX_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  cmd_t             stage,
  input  logic             in_first,
  input  logic [IDX_W-1:0] byte_idx,
  input  logic             idx_ok,
  input  logic             byte_vld,
  input  logic [7:0]       byte_in,
  output logic [7:0]       byte_out,
  output logic             test_mode
);
  cmd_t             work_q;
  logic             test_mode_q;
  logic [IDX_W-1:0] ofs_a;
  logic [IDX_W-1:0] ofs_b;
  logic             hit_a;
  logic             hit_b;
  logic             hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      work_q      <= '0;
      test_mode_q <= 1'b0;
    end else if (load) begin
      work_q      <= stage;
      test_mode_q <= kind_active(stage.kind);
    end
  end

  assign ofs_a = IDX_W'(work_q.ofs);
  assign ofs_b = ofs_a + IDX_W'(1);
  assign hit_a = (byte_idx == ofs_a);
  assign hit_b = (work_q.kind == K_DOUBLE) && (byte_idx == ofs_b);
  assign hit   = byte_vld && in_first && idx_ok && kind_active(work_q.kind) && (hit_a || hit_b);

  assign byte_out  = hit ? (byte_in ^ work_q.mask) : byte_in;
  assign test_mode = test_mode_q;

  AST_WORK_HOLD: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(work_q)); // R7
  AST_PASS_OUTSIDE_FIRST: assert property (@(posedge clk) disable iff (rst)
    (byte_vld && !in_first) |-> byte_out == byte_in); // R6
  AST_BAD_KIND_QUIET: assert property (@(posedge clk) disable iff (rst)
    (work_q.kind == K_BAD) |-> (!test_mode_q && byte_out == byte_in)); // R4
  AST_NONE_KIND_QUIET: assert property (@(posedge clk) disable iff (rst)
    (work_q.kind == K_NONE) |-> byte_out == byte_in); // R3
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (byte_vld && !idx_ok) |-> byte_out == byte_in); // R9
  AST_FLAG_TRACKS_WORK: assert property (@(posedge clk) disable iff (rst)
    test_mode_q == kind_active(work_q.kind)); // R10
  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (rst)
    $onehot0({hit_a, hit_b})); // R8
endmodule

// File: rtl/rb_fault_injector.sv
module rb_fault_injector
  import rfi_pkg::*;
#(
  parameter int              FRAME_BYTES = 64,
  parameter int              IR_W        = 10,
  parameter logic [IR_W-1:0] INJ_OPCODE  = 10'b0000010101
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       user_mode,
  input  logic       tdi,
  input  logic       tap_capture_ir,
  input  logic       tap_shift_ir,
  input  logic       tap_update_ir,
  input  logic       tap_capture_dr,
  input  logic       tap_shift_dr,
  input  logic       tap_update_dr,
  output logic       tdo,
  input  logic       rb_frame_start,
  input  logic       rb_frame_first,
  input  logic       rb_frame_last,
  input  logic       rb_frame_end,
  input  logic       rb_byte_vld,
  input  logic [7:0] rb_byte_in,
  output logic [7:0] rb_byte_out,
  output logic       err_test_mode
);
  localparam int IDX_W = OFS_W + 1;

  cmd_t             stage;
  logic             in_first;
  logic [IDX_W-1:0] byte_idx;
  logic             idx_ok;
  logic             load;

  rfi_tap_regs #(.IR_W(IR_W), .OPCODE(INJ_OPCODE)) u_tap (
    .clk(clk), .rst(rst), .user_mode(user_mode), .tdi(tdi),
    .cap_ir(tap_capture_ir), .shift_ir(tap_shift_ir), .upd_ir(tap_update_ir),
    .cap_dr(tap_capture_dr), .shift_dr(tap_shift_dr), .upd_dr(tap_update_dr),
    .tdo(tdo), .stage(stage)
  );

  rfi_frame_track #(.FRAME_BYTES(FRAME_BYTES), .IDX_W(IDX_W)) u_track (
    .clk(clk), .rst(rst),
    .frm_start(rb_frame_start), .frm_first(rb_frame_first),
    .frm_last(rb_frame_last), .frm_end(rb_frame_end),
    .byte_vld(rb_byte_vld), .in_first(in_first),
    .byte_idx(byte_idx), .idx_ok(idx_ok), .load(load)
  );

  rfi_corrupt #(.IDX_W(IDX_W)) u_corrupt (
    .clk(clk), .rst(rst), .load(load), .stage(stage),
    .in_first(in_first), .byte_idx(byte_idx), .idx_ok(idx_ok),
    .byte_vld(rb_byte_vld), .byte_in(rb_byte_in),
    .byte_out(rb_byte_out), .test_mode(err_test_mode)
  );

  AST_RESET_CLEARS_FLAG: assert property (@(posedge clk)
    rst |=> !err_test_mode); // R11
  AST_FLAG_MOVES_ON_END: assert property (@(posedge clk) disable iff (rst)
    !rb_frame_end |=> $stable(err_test_mode)); // R10
endmodule

// File: tb/rb_fault_injector_bench.sv
module rb_fault_injector_bench;
  localparam int CLK_PERIOD = 10;
  localparam int FB = 16;
  localparam logic [9:0] OP_INJ = 10'b0000010101;
  localparam logic [9:0] OP_OTHER = 10'b0000000111;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic user_mode = 1'b1;
  logic tdi = 1'b0;
  logic cap_ir = 1'b0, sh_ir = 1'b0, up_ir = 1'b0;
  logic cap_dr = 1'b0, sh_dr = 1'b0, up_dr = 1'b0;
  logic tdo;
  logic f_start = 1'b0, f_first = 1'b0, f_last = 1'b0, f_end = 1'b0;
  logic b_vld = 1'b0;
  logic [7:0] b_in = 8'h00;
  logic [7:0] b_out;
  logic err_tm;

  int checks = 0;
  int errors = 0;
  logic [20:0] m_stage = '0;
  logic [20:0] m_work  = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rb_fault_injector #(.FRAME_BYTES(FB)) u_rb_fault_injector (
    .clk(clk), .rst(rst), .user_mode(user_mode), .tdi(tdi),
    .tap_capture_ir(cap_ir), .tap_shift_ir(sh_ir), .tap_update_ir(up_ir),
    .tap_capture_dr(cap_dr), .tap_shift_dr(sh_dr), .tap_update_dr(up_dr),
    .tdo(tdo), .rb_frame_start(f_start), .rb_frame_first(f_first),
    .rb_frame_last(f_last), .rb_frame_end(f_end), .rb_byte_vld(b_vld),
    .rb_byte_in(b_in), .rb_byte_out(b_out), .err_test_mode(err_tm)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic active(logic [20:0] c);
    return c[20:19] == 2'b01 || c[20:19] == 2'b10;
  endfunction

  function automatic logic [7:0] exp_byte(logic first, int idx, logic [7:0] d);
    int ofs;
    ofs = int'(m_work[18:8]);
    if (first && idx < FB && active(m_work) &&
        (idx == ofs || (m_work[20:19] == 2'b10 && idx == ofs + 1)))
      return d ^ m_work[7:0];
    return d;
  endfunction

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    m_stage = '0; m_work = '0;
  endtask

  task automatic ir_load(logic [9:0] op);
    @(negedge clk); cap_ir = 1'b1;
    @(negedge clk); cap_ir = 1'b0; sh_ir = 1'b1;
    for (int i = 0; i < 10; i++) begin
      tdi = op[i];
      @(negedge clk);
    end
    sh_ir = 1'b0; up_ir = 1'b1;
    @(negedge clk); up_ir = 1'b0;
  endtask

  task automatic dr_write(logic [20:0] v);
    @(negedge clk); cap_dr = 1'b1;
    @(negedge clk); cap_dr = 1'b0; sh_dr = 1'b1;
    for (int i = 0; i < 21; i++) begin
      tdi = v[i];
      @(negedge clk);
    end
    sh_dr = 1'b0; up_dr = 1'b1;
    @(negedge clk); up_dr = 1'b0;
    if (user_mode) m_stage = v;
  endtask

  task automatic dr_read(output logic [20:0] v);
    @(negedge clk); cap_dr = 1'b1;
    @(negedge clk); cap_dr = 1'b0; sh_dr = 1'b1; tdi = 1'b0;
    for (int i = 0; i < 21; i++) begin
      #1 v[i] = tdo;
      @(negedge clk);
    end
    sh_dr = 1'b0;
  endtask

  task automatic send_frame(logic first, logic last, logic [7:0] seed, string tag);
    @(negedge clk); f_start = 1'b1; f_first = first; f_last = last;
    @(negedge clk); f_start = 1'b0; f_first = 1'b0; f_last = 1'b0;
    for (int i = 0; i < FB + 2; i++) begin
      b_vld = 1'b1;
      b_in  = 8'(i * 37) ^ seed;
      #1 check(tag, 32'(b_out), 32'(exp_byte(first, i, b_in)));
      @(negedge clk);
    end
    b_vld = 1'b0; f_end = 1'b1;
    @(negedge clk); f_end = 1'b0;
    if (first || !last) m_work = m_stage;
    #1 check({tag, " R10 flag"}, 32'(err_tm), 32'(active(m_work)));
  endtask

  task automatic run_pass(logic [7:0] seed, string tag);
    send_frame(1'b1, 1'b0, seed, tag);
    send_frame(1'b0, 1'b0, seed + 8'd1, {tag, " R6 mid"});
    send_frame(1'b0, 1'b1, seed + 8'd2, {tag, " R6 last"});
  endtask

  task automatic t_reset();
    logic [20:0] rd;
    do_reset();
    #1 check("R11 flag after reset", 32'(err_tm), 32'd0);
    send_frame(1'b1, 1'b1, 8'h11, "R11 passthrough");
    ir_load(OP_INJ);
    dr_read(rd);
    check("R11 staging zero", 32'(rd), 32'd0);
  endtask

  task automatic t_access();
    logic [20:0] rd;
    dr_write(21'h0A_5C3);
    dr_read(rd);
    check("R1 readback", 32'(rd), 32'h0A_5C3);
    ir_load(OP_OTHER);
    @(negedge clk); sh_dr = 1'b1;
    for (int i = 0; i < 4; i++) begin
      tdi = 1'b1;
      #1 check("R1 tdo quiet", 32'(tdo), 32'd0);
      @(negedge clk);
    end
    sh_dr = 1'b0; up_dr = 1'b1;
    @(negedge clk); up_dr = 1'b0;
    ir_load(OP_INJ);
    dr_read(rd);
    check("R1 other instr no write", 32'(rd), 32'h0A_5C3);
  endtask

  task automatic t_user_mode();
    logic [20:0] rd;
    user_mode = 1'b0;
    dr_write(21'h1F_FFFF);
    user_mode = 1'b1;
    dr_read(rd);
    check("R2 ignored off user mode", 32'(rd), 32'h0A_5C3);
  endtask

  task automatic t_single();
    dr_write({2'b01, 11'd3, 8'hA5});
    run_pass(8'h20, "R3 R5 single prime");
    run_pass(8'h30, "R3 R5 single");
  endtask

  task automatic t_double();
    dr_write({2'b10, 11'd5, 8'h3C});
    run_pass(8'h40, "R8 double prime");
    run_pass(8'h50, "R8 double");
  endtask

  task automatic t_invalid();
    dr_write({2'b11, 11'd2, 8'hFF});
    run_pass(8'h60, "R4 invalid kind");
    send_frame(1'b1, 1'b1, 8'h61, "R4 invalid single-frame pass");
    dr_write({2'b00, 11'd2, 8'hFF});
    send_frame(1'b1, 1'b1, 8'h62, "R3 none kind");
  endtask

  task automatic t_boundary();
    dr_write({2'b10, 11'(FB - 1), 8'h81});
    run_pass(8'h70, "R9 edge double");
    send_frame(1'b1, 1'b0, 8'h71, "R9 edge double");
    dr_write({2'b01, 11'(FB + 1), 8'hF0});
    send_frame(1'b0, 1'b1, 8'h72, "R9 last");
    send_frame(1'b1, 1'b0, 8'h73, "R9 beyond frame");
    send_frame(1'b1, 1'b0, 8'h74, "R9 beyond frame");
  endtask

  task automatic t_window();
    dr_write({2'b01, 11'd7, 8'h0F});
    send_frame(1'b0, 1'b0, 8'h80, "R7 middle loads");
    dr_write({2'b11, 11'd1, 8'hF0});
    send_frame(1'b0, 1'b1, 8'h81, "R7 last holds");
    send_frame(1'b1, 1'b0, 8'h82, "R7 first uses old");
    dr_write({2'b10, 11'd0, 8'h55});
    send_frame(1'b0, 1'b1, 8'h83, "R7 last holds again");
    send_frame(1'b1, 1'b0, 8'h84, "R7 first loads at end");
    send_frame(1'b1, 1'b0, 8'h85, "R7 new value applies");
  endtask

  task automatic t_reset_end();
    logic [20:0] rd;
    #1 check("R11 flag before reset", 32'(err_tm), 32'd1);
    do_reset();
    #1 check("R11 flag cleared", 32'(err_tm), 32'd0);
    send_frame(1'b1, 1'b1, 8'h90, "R11 work cleared");
    ir_load(OP_INJ);
    dr_read(rd);
    check("R11 staging cleared", 32'(rd), 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog all requirements actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_access();
    t_user_mode();
    t_single();
    t_double();
    t_invalid();
    t_boundary();
    t_window();
    t_reset_end();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule